// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block produces the column address for every data element of a DRAM read or write burst. A mode-register load chooses the burst length (2, 4 or 8 elements) and the beat ordering (sequential or interleaved). A start strobe supplies the starting column. The block then presents one column per beat and moves to the next beat each time the advance input is high.

For all beats of a burst, the column bits above the burst field do not change, so every access stays inside one aligned block. In sequential ordering, the low field counts up from the start value and wraps at the block edge. In interleaved ordering, the low field is the start value XOR the beat index. The length and ordering in force when a burst starts are copied at the start strobe and hold until that burst ends.

Top module: `burst_col_seq`

## Requirements
- R1: After reset, `col_valid` and `col_last` are low. The active setting is burst length 2 with sequential ordering.
- R2: A load with `mrs_en` high and `mrs_bank` equal to 0 takes the length code from `mrs_addr[2:0]` and the ordering from `mrs_addr[3]`. Length codes are 001 for 2, 010 for 4 and 011 for 8. Ordering is 0 for sequential and 1 for interleaved. A burst started afterwards uses the new setting.
- R3: A load with any nonzero `mrs_bank` leaves both length and ordering unchanged.
- R4: A load with a length code other than 001, 010 or 011 is ignored as a whole, and the previous length and ordering are kept.
- R5: The column bits above the low log2(length) bits equal those of the starting column on every beat of the burst.
- R6: In sequential ordering, the low field of beat i is (start + i) mod length. For example, length 8 from 5 gives 5-6-7-0-1-2-3-4.
- R7: In interleaved ordering, the low field of beat i is start XOR i. For example, length 8 from 5 gives 5-4-7-6-1-0-3-2.
- R8: `col_last` is high only on the final beat (index length-1). An advance on that beat ends the burst, and `col_valid` falls on the next cycle.
- R9: A start strobe always begins a new burst from its column, even during an active burst, and it takes priority over an advance in the same cycle.
- R10: While a burst is active and neither advance nor start is high, the column and flags stay the same.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mrs_en | input | 1 | Mode-register load strobe |
| mrs_bank | input | BANK_W | Bank bits of the load; must be 0 for the base register |
| mrs_addr | input | MODE_W | Address bits of the load; [2:0] length code, [3] ordering |
| start | input | 1 | Column command strobe that begins a burst |
| start_col | input | COL_W | Starting column of the burst |
| advance | input | 1 | Move to the next beat |
| col | output | COL_W | Column for the current beat |
| col_valid | output | 1 | A burst beat is being presented |
| col_last | output | 1 | The current beat is the final one |

## Verification
All results are due one clock edge after their stimulus:
- The first beat appears at the edge that samples `start`.
- Each following beat appears at the edge that samples `advance`.
- A mode load affects only bursts that start after the edge that samples it.
- `col_valid` falls at the edge that samples the advance on the last beat.

The bench drives inputs shortly after a rising edge and reads outputs at the same point after the next edge. This way each check sees exactly one register update. Stall cycles are inserted to confirm the beat holds. Restarts in mid-burst are checked on the beat that follows the strobe.

// File: rtl/burst_col_seq.sv
module burst_col_seq #(
  parameter int COL_W  = 10,
  parameter int MODE_W = 13,
  parameter int BANK_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mrs_en,
  input  logic [BANK_W-1:0] mrs_bank,
  input  logic [MODE_W-1:0] mrs_addr,
  input  logic              start,
  input  logic [COL_W-1:0]  start_col,
  input  logic              advance,
  output logic [COL_W-1:0]  col,
  output logic              col_valid,
  output logic              col_last
);
  localparam int BW = 3;

  logic [BW-1:0]    len_code, run_code;
  logic             ilv, run_ilv;
  logic [COL_W-1:0] base;
  logic [BW-1:0]    beat;
  logic             active;

  wire code_ok = (mrs_addr[2:0] == 3'd1) || (mrs_addr[2:0] == 3'd2) || (mrs_addr[2:0] == 3'd3);
  wire mode_we = mrs_en && (mrs_bank == '0) && code_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      len_code <= 3'd1;
      ilv      <= 1'b0;
    end else if (mode_we) begin
      len_code <= mrs_addr[2:0];
      ilv      <= mrs_addr[3];
    end
  end

  wire [BW-1:0] last_idx = BW'((4'd1 << run_code) - 4'd1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active   <= 1'b0;
      base     <= '0;
      beat     <= '0;
      run_code <= 3'd1;
      run_ilv  <= 1'b0;
    end else if (start) begin
      active   <= 1'b1;
      base     <= start_col;
      beat     <= '0;
      run_code <= len_code;
      run_ilv  <= ilv;
    end else if (active && advance) begin
      if (beat == last_idx) active <= 1'b0;
      else                  beat   <= beat + 1'b1;
    end
  end

  wire [COL_W-1:0] mask    = (COL_W'(1) << run_code) - COL_W'(1);
  wire [BW-1:0]    low_seq = base[BW-1:0] + beat;
  wire [BW-1:0]    low_ilv = base[BW-1:0] ^ beat;
  wire [BW-1:0]    low     = run_ilv ? low_ilv : low_seq;

  assign col       = (base & ~mask) | (COL_W'(low) & mask);
  assign col_valid = active;
  assign col_last  = active && (beat == last_idx);

  p_reset_idle_r1: assert property (@(posedge clk) !rst_n |=> !col_valid && !col_last);
  p_bank_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mrs_en && (mrs_bank != '0) |=> $stable(len_code) && $stable(ilv));
  p_code_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mrs_en && !code_ok |=> $stable(len_code) && $stable(ilv));
  p_block_fixed_r5: assert property (@(posedge clk) disable iff (!rst_n)
    col_valid && advance && !col_last && !start |=> col_valid && col[COL_W-1:BW] == $past(col[COL_W-1:BW]) && col != $past(col));
  p_last_valid_r8: assert property (@(posedge clk) disable iff (!rst_n) col_last |-> col_valid);
  p_end_burst_r8: assert property (@(posedge clk) disable iff (!rst_n)
    col_last && advance && !start |=> !col_valid);
  p_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> col_valid && col == $past(start_col));
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    col_valid && !advance && !start |=> col_valid && $stable(col) && $stable(col_last));
endmodule

// File: tb/sim_burst_col_seq.sv
module sim_burst_col_seq;
  localparam int COL_W = 10;
  logic clk = 0, rst_n = 0, mrs_en = 0, start = 0, advance = 0;
  logic [1:0] mrs_bank = 0;
  logic [12:0] mrs_addr = 0;
  logic [COL_W-1:0] start_col = 0, col;
  logic col_valid, col_last;
  int checks = 0, errors = 0;
  int m_log = 1;
  bit m_ilv = 0;

  always #2 clk = ~clk;

  burst_col_seq #(.COL_W(COL_W)) u0 (.clk, .rst_n, .mrs_en, .mrs_bank, .mrs_addr,
    .start, .start_col, .advance, .col, .col_valid, .col_last);

  task automatic tick; @(posedge clk); #1; endtask

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int exp_col(int b, int i, int lg, bit il);
    int m = (1 << lg) - 1;
    int lo = il ? ((b ^ i) & m) : ((b + i) & m);
    return (b & ~m) | lo;
  endfunction

  task automatic load(int bank, int addr);
    mrs_en = 1; mrs_bank = 2'(bank); mrs_addr = 13'(addr);
    tick;
    mrs_en = 0;
    if (bank == 0 && (addr & 7) >= 1 && (addr & 7) <= 3) begin
      m_log = addr & 7; m_ilv = addr[3];
    end
  endtask

  task automatic burst(int b, bit stalls, string req);
    int len = 1 << m_log;
    start = 1; start_col = COL_W'(b);
    tick;
    start = 0;
    for (int i = 0; i < len; i++) begin
      chk(col_valid == 1, req, col_valid, 1);
      chk(col == COL_W'(exp_col(b, i, m_log, m_ilv)), req, col, exp_col(b, i, m_log, m_ilv));
      chk(col_last == (i == len - 1), "R8", col_last, i == len - 1);
      if (stalls && ($urandom % 3 == 0)) begin
        tick;
        chk(col == COL_W'(exp_col(b, i, m_log, m_ilv)) && col_valid, "R10", col,
            exp_col(b, i, m_log, m_ilv));
      end
      advance = 1; tick; advance = 0;
    end
    chk(col_valid == 0, "R8 end", col_valid, 0);
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    process::self().srandom(32'd12345);
    tick; tick;
    chk(!col_valid && !col_last, "R1", col_valid, 0);
    rst_n = 1; tick;
    burst('h3, 0, "R1 default len2 seq");
    load(0, 'h3);  burst('h2AD, 0, "R6 len8 seq from 5");
    load(0, 'hB);  burst('h2AD, 0, "R7 len8 ilv from 5");
    load(0, 'h2);  burst('h17E, 0, "R2 len4 seq");
    load(1, 'hB);  burst('h17E, 0, "R3 bank ignored");
    load(2, 'h9);  burst('h0F1, 0, "R3 bank ignored");
    load(0, 'hC);  burst('h0F1, 0, "R4 reserved ignored");
    load(0, 'h7);  burst('h3FF, 0, "R4 reserved ignored");
    load(0, 'hA);  burst('h3FF, 0, "R5 len4 ilv block");
    // R9: restart mid-burst, start wins over advance
    load(0, 'h3);
    start = 1; start_col = 'h10; tick; start = 0;
    advance = 1; tick; tick;
    start = 1; start_col = 'h2C6; tick; start = 0; advance = 0;
    chk(col_valid && col == 'h2C6, "R9 restart", col, 'h2C6);
    chk(!col_last, "R9 restart", col_last, 0);
    advance = 1; tick; advance = 0;
    chk(col == COL_W'(exp_col('h2C6, 1, 3, 0)), "R9 restart", col, exp_col('h2C6, 1, 3, 0));
    for (int i = 1; i < 8; i++) begin advance = 1; tick; end
    advance = 0;
    chk(!col_valid, "R9 end", col_valid, 0);
    for (int n = 0; n < 60; n++) begin
      int sel = $urandom % 8;
      int bank = (sel == 0) ? 1 + $urandom % 3 : 0;
      load(bank, $urandom % 16);
      burst($urandom % (1 << COL_W), 1, m_ilv ? "R7 random" : "R6 random");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule